// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independently clocked ports, A and B, a pair of single-word mailbox registers. Messages bypass a bulk data FIFO that sits outside the block. Mailbox 1 carries a word from A to B, and mailbox 2 carries a word from B to A. Each port presents an access strobe, a write/read select, a mailbox select and a data bus. The two write/read selects have opposite polarity. Port A drives high to write. Port B drives high to read.

Each mailbox has an active-low full flag in the writer's clock domain. A write drops the flag, and the flag blocks further writes until the reader has taken the word. The reader's domain has a matching "available" indication. The clear made by the reader crosses back to the writer through a toggle handshake with synchronizers, and the flag rises again once that clear arrives. When the mailbox select is low, port A's write is routed to the FIFO write path and port B's read shows the FIFO output word. Port B's write with select low goes nowhere.

Top module: `mbox_pair`

## Requirements
- R1: On a clk_a edge with a_en=1, a_wr=1 (write) and a_mb_sel=1, while a_m1_full_n=1, the word on a_wdata is stored in mailbox 1, and a_m1_full_n is 0 after that edge. With a_mb_sel=0, mailbox 1 and a_m1_full_n are untouched. In that case a_fifo_we is 1 and a_fifo_wdata equals a_wdata after the edge.
- R2: On a clk_b edge with b_en=1 and b_rd=1 (read), b_rdata takes the mailbox 1 word when b_mb_sel=1, and takes b_fifo_rdata when b_mb_sel=0.
- R3: On a clk_b edge with b_en=1, b_rd=0 (write) and b_mb_sel=1, while b_m2_full_n=1, b_wdata is stored in mailbox 2, and b_m2_full_n is 0 after that edge. With b_mb_sel=0, the write has no effect on mailbox 2 or its flags.
- R4: A write to a mailbox whose full flag is 0 is ignored. The stored word stays as it was.
- R5: A mailbox read with the select high while the word is available makes the reader's available output 0 after that edge. The writer's full flag returns to 1 within a few writer clocks, through the synchronizers.
- R6: A reader's available output rises no earlier than two reader clock edges after the write. While it is high, the stored word is stable and stays available until read.
- R7: rst_a and rst_b are synchronous and active high. Applied together, they force both full flags to 1 and both available outputs to 0. They also force a_rdata and b_rdata to zero.
- R8: b_m2_clr=1 on a clk_b edge sets the mailbox 2 word to zero. It cancels a mailbox 2 write in the same cycle, so b_m2_full_n stays 1.
- R9: On a clk_a edge with a_en=1, a_wr=0 (read) and a_mb_sel=1, a_rdata takes the mailbox 2 word. An A read with a_mb_sel=0 leaves a_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_en | input | 1 | Port A access strobe |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mb_sel | input | 1 | Port A mailbox select, 0 = FIFO path |
| a_wdata | input | DW | Port A write word |
| a_rdata | output | DW | Port A read word (mailbox 2) |
| a_fifo_we | output | 1 | Registered FIFO write strobe |
| a_fifo_wdata | output | DW | Registered FIFO write word |
| a_m1_full_n | output | 1 | Mailbox 1 full flag, active low |
| a_m2_avail | output | 1 | Mailbox 2 holds an unread word |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_m2_clr | input | 1 | Clear the mailbox 2 word |
| b_en | input | 1 | Port B access strobe |
| b_rd | input | 1 | Port B direction, 1 = read, 0 = write |
| b_mb_sel | input | 1 | Port B mailbox select, 0 = FIFO path |
| b_wdata | input | DW | Port B write word (mailbox 2 only) |
| b_fifo_rdata | input | DW | FIFO output register word |
| b_rdata | output | DW | Port B read word |
| b_m2_full_n | output | 1 | Mailbox 2 full flag, active low |
| b_m1_avail | output | 1 | Mailbox 1 holds an unread word |

## Verification
The collision that matters is a reader's clear landing in the same stretch of cycles as the writer's next write attempt. The bench holds a port A mailbox write asserted on every clk_a cycle while port B reads the pending word. It then checks two things. B must receive the first word, not the blocked one. The held word must enter the mailbox only once the flag has visibly risen, after which B reads it intact. A second overlap is covered too: a mailbox 2 clear in the same clk_b cycle as a mailbox 2 write, judged by the flag staying high and A reading back zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  // A mailbox holds a word when the two toggles disagree.
  function automatic logic tog_pending(input logic wtog, input logic rtog);
    return wtog ^ rtog;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_req,
  input  logic          wclr,
  input  logic [DW-1:0] wdata,
  output logic          full_n,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_req,
  output logic          avail,
  output logic [DW-1:0] mdata
);
  import mbox_pkg::*;

  logic wtog, rtog, rtog_w, wtog_r, wacc, racc;
  logic [DW-1:0] mem;

  // writer side
  assign full_n = ~tog_pending(wtog, rtog_w);
  assign wacc   = wr_req & full_n & ~wclr;

  always_ff @(posedge wclk) begin
    if (wrst)      wtog <= 1'b0;
    else if (wacc) wtog <= ~wtog;
  end

  always_ff @(posedge wclk) begin
    if (wclr)      mem <= '0;
    else if (wacc) mem <= wdata;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (.clk(rclk), .rst(rrst), .d(wtog), .q(wtog_r));
  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (.clk(wclk), .rst(wrst), .d(rtog), .q(rtog_w));

  // reader side
  assign avail = tog_pending(wtog_r, rtog);
  assign racc  = rd_req & avail;

  always_ff @(posedge rclk) begin
    if (rrst)      rtog <= 1'b0;
    else if (racc) rtog <= ~rtog;
  end

  assign mdata = mem;

  AST_WR_SETS_FULL: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && full_n && !wclr) |=> !full_n); // R1
  AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && !full_n && !wclr) |=> $stable(mdata)); // R4
  AST_READ_CLEARS: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && avail) |=> !avail); // R5
  AST_AVAIL_HOLDS: assert property (@(posedge rclk) disable iff (rrst)
    (avail && !rd_req) |=> avail); // R6
  AST_CLR_WINS: assert property (@(posedge wclk) disable iff (wrst)
    wclr |=> (mdata == '0)); // R8
  AST_RST_FLAG: assert property (@(posedge wclk)
    wrst |=> full_n); // R7
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_mb_sel,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_fifo_we,
  output logic [DW-1:0] a_fifo_wdata,
  output logic          a_m1_full_n,
  output logic          a_m2_avail,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          b_m2_clr,
  input  logic          b_en,
  input  logic          b_rd,
  input  logic          b_mb_sel,
  input  logic [DW-1:0] b_wdata,
  input  logic [DW-1:0] b_fifo_rdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_m2_full_n,
  output logic          b_m1_avail
);
  logic          a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd, b_any_rd;
  logic [DW-1:0] m1_word, m2_word;

  assign a_mb_wr  = a_en &  a_wr & a_mb_sel;
  assign a_mb_rd  = a_en & ~a_wr & a_mb_sel;
  assign b_any_rd = b_en &  b_rd;
  assign b_mb_rd  = b_any_rd & b_mb_sel;
  assign b_mb_wr  = b_en & ~b_rd & b_mb_sel;

  mbox_channel #(.DW(DW)) u_mail1 (
    .wclk(clk_a), .wrst(rst_a), .wr_req(a_mb_wr), .wclr(1'b0), .wdata(a_wdata),
    .full_n(a_m1_full_n),
    .rclk(clk_b), .rrst(rst_b), .rd_req(b_mb_rd), .avail(b_m1_avail), .mdata(m1_word)
  );

  mbox_channel #(.DW(DW)) u_mail2 (
    .wclk(clk_b), .wrst(rst_b), .wr_req(b_mb_wr), .wclr(b_m2_clr), .wdata(b_wdata),
    .full_n(b_m2_full_n),
    .rclk(clk_a), .rrst(rst_a), .rd_req(a_mb_rd), .avail(a_m2_avail), .mdata(m2_word)
  );

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      a_rdata      <= '0;
      a_fifo_we    <= 1'b0;
      a_fifo_wdata <= '0;
    end else begin
      a_fifo_we <= a_en & a_wr & ~a_mb_sel;
      if (a_en & a_wr & ~a_mb_sel) a_fifo_wdata <= a_wdata;
      if (a_mb_rd)                 a_rdata      <= m2_word;
    end
  end

  always_ff @(posedge clk_b) begin
    if (rst_b)         b_rdata <= '0;
    else if (b_any_rd) b_rdata <= b_mb_sel ? m1_word : b_fifo_rdata;
  end

  AST_A_SEL_LOW_NO_MAIL: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_en && a_wr && !a_mb_sel && a_m1_full_n) |=> a_m1_full_n); // R1
  AST_B_SEL_LOW_NO_MAIL: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_en && !b_rd && !b_mb_sel && b_m2_full_n) |=> b_m2_full_n); // R3
  AST_A_RDATA_HOLDS: assert property (@(posedge clk_a) disable iff (rst_a)
    !(a_en && !a_wr && a_mb_sel) |=> $stable(a_rdata)); // R9
endmodule

// File: tb/tb_mbox_pair.sv
`timescale 1ns/1ps
module tb_mbox_pair;
  localparam int unsigned DW = 32;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a, rst_b, b_m2_clr;
  logic a_en, a_wr, a_mb_sel, b_en, b_rd, b_mb_sel;
  logic [DW-1:0] a_wdata, b_wdata, b_fifo_rdata;
  logic [DW-1:0] a_rdata, a_fifo_wdata, b_rdata;
  logic a_fifo_we, a_m1_full_n, a_m2_avail, b_m2_full_n, b_m1_avail;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_a = ~clk_a;   // 50 MHz
  always #7  clk_b = ~clk_b;

  mbox_pair #(.DW(DW)) dut (
    .clk_a(clk_a), .rst_a(rst_a), .a_en(a_en), .a_wr(a_wr), .a_mb_sel(a_mb_sel),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_fifo_we(a_fifo_we), .a_fifo_wdata(a_fifo_wdata),
    .a_m1_full_n(a_m1_full_n), .a_m2_avail(a_m2_avail),
    .clk_b(clk_b), .rst_b(rst_b), .b_m2_clr(b_m2_clr), .b_en(b_en), .b_rd(b_rd),
    .b_mb_sel(b_mb_sel), .b_wdata(b_wdata), .b_fifo_rdata(b_fifo_rdata), .b_rdata(b_rdata),
    .b_m2_full_n(b_m2_full_n), .b_m1_avail(b_m1_avail)
  );

  function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] seed, input int k);
    return seed ^ (DW'(k) << 3) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic a_op(input logic wr, input logic sel, input logic [DW-1:0] d);
    a_en = 1'b1; a_wr = wr; a_mb_sel = sel; a_wdata = d;
    @(negedge clk_a);
    a_en = 1'b0;
  endtask

  task automatic b_op(input logic rd, input logic sel, input logic [DW-1:0] d, input logic clr);
    b_en = 1'b1; b_rd = rd; b_mb_sel = sel; b_wdata = d; b_m2_clr = clr;
    @(negedge clk_b);
    b_en = 1'b0; b_m2_clr = 1'b0;
  endtask

  task automatic wait_b_avail(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (b_m1_avail) begin ok = 1'b1; break; end
      @(negedge clk_b);
    end
  endtask

  task automatic wait_a_avail(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (a_m2_avail) begin ok = 1'b1; break; end
      @(negedge clk_a);
    end
  endtask

  task automatic wait_a_free(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (a_m1_full_n) begin ok = 1'b1; break; end
      @(negedge clk_a);
    end
  endtask

  task automatic wait_b_free(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (b_m2_full_n) begin ok = 1'b1; break; end
      @(negedge clk_b);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, v2, seed, hold;
    bit ok;
    void'($urandom(32'd1234));
    rst_a = 1'b1; rst_b = 1'b1; b_m2_clr = 1'b0;
    a_en = 1'b0; a_wr = 1'b0; a_mb_sel = 1'b0; a_wdata = '0;
    b_en = 1'b0; b_rd = 1'b0; b_mb_sel = 1'b0; b_wdata = '0; b_fifo_rdata = '0;
    repeat (6) @(negedge clk_a);
    rst_a = 1'b0;
    @(negedge clk_b);
    rst_b = 1'b0;
    repeat (3) @(negedge clk_a);

    // R7 reset state
    check(a_m1_full_n == 1'b1, "R7 a_m1_full_n", a_m1_full_n, 1);
    check(b_m2_full_n == 1'b1, "R7 b_m2_full_n", b_m2_full_n, 1);
    check(b_m1_avail == 1'b0,  "R7 b_m1_avail", b_m1_avail, 0);
    check(a_m2_avail == 1'b0,  "R7 a_m2_avail", a_m2_avail, 0);
    check(a_rdata == '0,       "R7 a_rdata", a_rdata, 0);
    check(b_rdata == '0,       "R7 b_rdata", b_rdata, 0);

    // R1 select low goes to FIFO path
    v = $urandom;
    a_op(1'b1, 1'b0, v);
    check(a_fifo_we == 1'b1,   "R1 fifo_we", a_fifo_we, 1);
    check(a_fifo_wdata == v,   "R1 fifo_wdata", a_fifo_wdata, v);
    check(a_m1_full_n == 1'b1, "R1 sel low flag", a_m1_full_n, 1);
    repeat (6) @(negedge clk_b);
    check(b_m1_avail == 1'b0,  "R1 sel low avail", b_m1_avail, 0);

    // R2 select low reads FIFO word
    @(negedge clk_b);
    b_fifo_rdata = $urandom;
    b_op(1'b1, 1'b0, '0, 1'b0);
    check(b_rdata == b_fifo_rdata, "R2 fifo read", b_rdata, b_fifo_rdata);

    // R3 B write with select low has no effect
    b_op(1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0);
    check(b_m2_full_n == 1'b1, "R3 sel low flag", b_m2_full_n, 1);
    repeat (6) @(negedge clk_a);
    check(a_m2_avail == 1'b0,  "R3 sel low avail", a_m2_avail, 0);

    // mailbox 1 random exchanges
    seed = $urandom;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_a);
      v  = exp_word(seed, k) ^ $urandom;
      v2 = ~v;
      a_op(1'b1, 1'b1, v);
      check(a_m1_full_n == 1'b0, "R1 flag low", a_m1_full_n, 0);
      check(b_m1_avail == 1'b0,  "R6 not early", b_m1_avail, 0);
      a_op(1'b1, 1'b1, v2);
      check(a_m1_full_n == 1'b0, "R4 still full", a_m1_full_n, 0);
      @(negedge clk_b);
      wait_b_avail(ok);
      check(ok, "R6 avail rises", ok, 1);
      b_op(1'b1, 1'b1, '0, 1'b0);
      check(b_rdata == v,        "R2 R4 mail1 word", b_rdata, v);
      check(b_m1_avail == 1'b0,  "R5 avail clears", b_m1_avail, 0);
      @(negedge clk_a);
      wait_a_free(ok);
      check(ok, "R5 flag returns", ok, 1);
    end

    // mailbox 2 random exchanges
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_b);
      v  = $urandom;
      v2 = v + 1;
      b_op(1'b0, 1'b1, v, 1'b0);
      check(b_m2_full_n == 1'b0, "R3 flag low", b_m2_full_n, 0);
      check(a_m2_avail == 1'b0,  "R6 not early m2", a_m2_avail, 0);
      b_op(1'b0, 1'b1, v2, 1'b0);
      check(b_m2_full_n == 1'b0, "R4 m2 still full", b_m2_full_n, 0);
      @(negedge clk_a);
      wait_a_avail(ok);
      check(ok, "R6 m2 avail rises", ok, 1);
      a_op(1'b0, 1'b1, '0);
      check(a_rdata == v,        "R9 R4 mail2 word", a_rdata, v);
      check(a_m2_avail == 1'b0,  "R5 m2 avail clears", a_m2_avail, 0);
      a_op(1'b0, 1'b0, '0);
      check(a_rdata == v,        "R9 sel low holds", a_rdata, v);
      @(negedge clk_b);
      wait_b_free(ok);
      check(ok, "R5 m2 flag returns", ok, 1);
    end

    // collision: A keeps writing while B clears
    @(negedge clk_a);
    v = $urandom; hold = v ^ 32'h0F0F_F0F0;
    a_op(1'b1, 1'b1, v);
    @(negedge clk_b);
    wait_b_avail(ok);
    check(ok, "R6 collision avail", ok, 1);
    fork
      begin
        @(negedge clk_b);
        b_op(1'b1, 1'b1, '0, 1'b0);
        check(b_rdata == v, "R4 collision first word", b_rdata, v);
      end
      begin
        @(negedge clk_a);
        for (int i = 0; i < 14; i++) a_op(1'b1, 1'b1, hold);
      end
    join
    check(a_m1_full_n == 1'b0, "R1 held write accepted", a_m1_full_n, 0);
    @(negedge clk_b);
    wait_b_avail(ok);
    check(ok, "R5 second word arrives", ok, 1);
    b_op(1'b1, 1'b1, '0, 1'b0);
    check(b_rdata == hold, "R5 second word", b_rdata, hold);
    @(negedge clk_a);
    wait_a_free(ok);

    // R8 clear beats a simultaneous write
    @(negedge clk_b);
    b_op(1'b0, 1'b1, 32'hCAFE_F00D, 1'b1);
    check(b_m2_full_n == 1'b1, "R8 write cancelled", b_m2_full_n, 1);
    @(negedge clk_a);
    a_op(1'b0, 1'b1, '0);
    check(a_rdata == '0, "R8 word cleared", a_rdata, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule